// File: doc/BRIEF.md
# Iterative 64-bit Block Cipher Encryption Datapath (IDEA round structure)

This block encrypts one 64-bit block with a fixed eight-round structure. Each round mixes three operations on 16-bit words: multiplication modulo 2^16+1 (an all-zero word stands for 2^16), addition modulo 2^16, and XOR. An output transform follows the eight rounds. The 52 subkeys are computed elsewhere and held in an external memory. The block reads them one per clock cycle through a read port that has a single cycle of latency, which suits an inferred block RAM.

To use the block, put the plaintext on the input and pulse start while the block is idle. The block splits the input into four words and walks the subkey addresses 0 to 51 in order. It applies one subkey per cycle, so one multiplier serves the whole datapath. Done pulses for one cycle when the ciphertext register is written, and the ciphertext then holds its value until the next operation completes.

Top module: `cipher64_core`

## Requirements
- R1: The plaintext is split big-endian: word A = plaintext[63:48], B = [47:32], C = [31:16], D = [15:0].
- R2: The modular multiply takes an operand of 0 to mean 2^16, and it returns 0 when the product modulo 65537 equals 2^16.
- R3: All additions are modulo 2^16. A carry out of bit 15 is dropped.
- R4: Each of the 8 rounds consumes subkeys 6r..6r+5 in this sequence. A=A*k0, B=B+k1, C=C+k2, D=D*k3. Then save C as u, C=(C^A)*k4. Save B as v, t=((B^D)+C)*k5. Then C=C+t, A=A^t, D=D^C, B=t^u, C=C^v.
- R5: The output step applies A*k48, C+k49, B+k50, D*k51, and the ciphertext is {A, C, B, D} with A in bits [63:48].
- R6: Once start is accepted, key_addr shows 0 in the next cycle and rises by one each cycle up to 51. The key data for an address is sampled one cycle after that address is presented.
- R7: Done is a one-cycle pulse. It appears 53 cycles after the edge at which start was accepted, and the block is idle while done is high.
- R8: A start pulse while the block is busy has no effect: the addressing, the latency and the result belong to the first block.
- R9: The ciphertext output changes only at the edge that raises done, and it holds its value otherwise.
- R10: After synchronous reset, done is 0, ciphertext is 0 and key_addr is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an encryption when the block is idle |
| plaintext | input | 64 | Block to encrypt, sampled with an accepted start |
| key_addr | output | 6 | Subkey read address (registered) |
| key_data | input | 16 | Subkey word returned one cycle after its address |
| ciphertext | output | 64 | Registered result |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest cases are the multiply corner cases inside a round, where an operand is zero or the product maps to 2^16. Operands such as (C^A) or ((B^D)+C) cannot be set directly from the ports. The stimulus mixes runs where every subkey is 0 or 0xFFFF with random subkey sets that have some zero entries, and with plaintexts that contain zero words. This drives the zero and wrap paths repeatedly through all 52 multiply and add steps. Separate runs raise start again at a fixed cycle in the middle of an operation, to show that the busy block ignores it.

// File: rtl/cipher64_pkg.sv
package cipher64_pkg;
  localparam int STEPS_PER_ROUND = 6;
  localparam int OUT_STEPS       = 4;

  function automatic int key_total(input int rounds);
    return rounds * STEPS_PER_ROUND + OUT_STEPS;
  endfunction

  typedef enum logic [2:0] {
    ST_MUL_A = 3'd0,
    ST_ADD_B = 3'd1,
    ST_ADD_C = 3'd2,
    ST_MUL_D = 3'd3,
    ST_MIX_E = 3'd4,
    ST_MIX_F = 3'd5
  } step_e;
endpackage

// File: rtl/c64_mulmod.sv
module c64_mulmod #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  localparam int PW = 2 * W;

  logic [PW-1:0] prod;
  logic [W-1:0]  lo;
  logic [W-1:0]  hi;

  always_comb begin
    prod = PW'(a) * PW'(b);
    lo   = prod[W-1:0];
    hi   = prod[PW-1:W];
    if (a == '0)
      y = W'(1) - b;
    else if (b == '0)
      y = W'(1) - a;
    else
      y = lo - hi + ((lo < hi) ? W'(1) : W'(0));
  end
endmodule

// File: rtl/c64_seq.sv
module c64_seq
  import cipher64_pkg::*;
#(
  parameter int ROUNDS = 8,
  parameter int KEY_N  = 52,
  parameter int KA_W   = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  output logic            busy,
  output logic            accept,
  output logic [KA_W-1:0] key_addr,
  output logic            proc_vld,
  output step_e           proc_step,
  output logic            proc_final,
  output logic            proc_last
);
  localparam int RW = $clog2(ROUNDS + 1);
  localparam logic [KA_W-1:0] LAST = KA_W'(KEY_N - 1);

  logic          iss_act;
  step_e         iss_step;
  logic [RW-1:0] iss_rnd;

  assign busy   = iss_act | proc_vld;
  assign accept = start & ~busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      iss_act    <= 1'b0;
      key_addr   <= '0;
      iss_step   <= ST_MUL_A;
      iss_rnd    <= '0;
      proc_vld   <= 1'b0;
      proc_step  <= ST_MUL_A;
      proc_final <= 1'b0;
      proc_last  <= 1'b0;
    end else begin
      proc_vld   <= iss_act;
      proc_step  <= iss_step;
      proc_final <= (iss_rnd == RW'(ROUNDS));
      proc_last  <= (key_addr == LAST);
      if (accept) begin
        iss_act  <= 1'b1;
        key_addr <= '0;
        iss_step <= ST_MUL_A;
        iss_rnd  <= '0;
      end else if (iss_act) begin
        if (key_addr == LAST)
          iss_act <= 1'b0;
        else
          key_addr <= key_addr + KA_W'(1);
        if (iss_step == ST_MIX_F) begin
          iss_step <= ST_MUL_A;
          iss_rnd  <= iss_rnd + RW'(1);
        end else begin
          iss_step <= step_e'(iss_step + 3'd1);
        end
      end
    end
  end
endmodule

// File: rtl/c64_datapath.sv
module c64_datapath
  import cipher64_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [4*W-1:0] pt,
  input  logic         vld,
  input  step_e        step,
  input  logic         final_step,
  input  logic         last,
  input  logic [W-1:0] key,
  output logic [4*W-1:0] ct,
  output logic         done
);
  logic [W-1:0] wa, wb, wc, wd, sav_c;
  logic [W-1:0] mul_a, mul_y, c_plus_t;

  always_comb begin
    case (step)
      ST_MUL_D: mul_a = wd;
      ST_MIX_E: mul_a = wc ^ wa;
      ST_MIX_F: mul_a = (wb ^ wd) + wc;
      default:  mul_a = wa;
    endcase
  end

  c64_mulmod #(.W(W)) u_mul (
    .a (mul_a),
    .b (key),
    .y (mul_y)
  );

  assign c_plus_t = wc + mul_y;

  always_ff @(posedge clk) begin
    if (rst) begin
      wa    <= '0;
      wb    <= '0;
      wc    <= '0;
      wd    <= '0;
      sav_c <= '0;
      ct    <= '0;
      done  <= 1'b0;
    end else begin
      done <= vld & last;
      if (load) begin
        wa <= pt[4*W-1:3*W];
        wb <= pt[3*W-1:2*W];
        wc <= pt[2*W-1:W];
        wd <= pt[W-1:0];
      end else if (vld) begin
        case (step)
          ST_MUL_A: wa <= mul_y;
          ST_ADD_B: begin
            if (final_step) wc <= wc + key;
            else            wb <= wb + key;
          end
          ST_ADD_C: begin
            if (final_step) wb <= wb + key;
            else            wc <= wc + key;
          end
          ST_MUL_D: begin
            wd <= mul_y;
            if (final_step) ct <= {wa, wc, wb, mul_y};
          end
          ST_MIX_E: begin
            sav_c <= wc;
            wc    <= mul_y;
          end
          ST_MIX_F: begin
            wa <= wa ^ mul_y;
            wb <= mul_y ^ sav_c;
            wc <= c_plus_t ^ wb;
            wd <= wd ^ c_plus_t;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/cipher64_core.sv
module cipher64_core
  import cipher64_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int ROUNDS = 8,
  localparam int KEY_N = key_total(ROUNDS),
  localparam int KA_W  = $clog2(KEY_N)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [4*WORD_W-1:0] plaintext,
  output logic [KA_W-1:0]     key_addr,
  input  logic [WORD_W-1:0]   key_data,
  output logic [4*WORD_W-1:0] ciphertext,
  output logic                done
);
  logic  busy, accept, proc_vld, proc_final, proc_last;
  step_e proc_step;

  c64_seq #(.ROUNDS(ROUNDS), .KEY_N(KEY_N), .KA_W(KA_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .busy       (busy),
    .accept     (accept),
    .key_addr   (key_addr),
    .proc_vld   (proc_vld),
    .proc_step  (proc_step),
    .proc_final (proc_final),
    .proc_last  (proc_last)
  );

  c64_datapath #(.W(WORD_W)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .load       (accept),
    .pt         (plaintext),
    .vld        (proc_vld),
    .step       (proc_step),
    .final_step (proc_final),
    .last       (proc_last),
    .key        (key_data),
    .ct         (ciphertext),
    .done       (done)
  );
endmodule

// File: rtl/cipher64_core_chk.sv
module cipher64_core_chk #(
  parameter int W     = 16,
  parameter int KEY_N = 52,
  parameter int KA_W  = 6
) (
  input logic            clk,
  input logic            rst,
  input logic            start,
  input logic            busy,
  input logic [KA_W-1:0] key_addr,
  input logic [4*W-1:0]  ciphertext,
  input logic            done
);
  localparam logic [KA_W-1:0] LAST = KA_W'(KEY_N - 1);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  p_ct_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(ciphertext));

  p_accept_r6: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && key_addr == '0));

  p_addr_seq_r6: assert property (@(posedge clk) disable iff (rst)
    (busy && key_addr < LAST) |=> (key_addr == $past(key_addr) + KA_W'(1)));

  p_no_restart_r8: assert property (@(posedge clk) disable iff (rst)
    (start && busy && key_addr < LAST) |=> (busy && key_addr != '0));
endmodule

bind cipher64_core cipher64_core_chk #(.W(WORD_W), .KEY_N(KEY_N), .KA_W(KA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .busy       (busy),
  .key_addr   (key_addr),
  .ciphertext (ciphertext),
  .done       (done)
);

// File: tb/cipher64_core_tb.sv
module cipher64_core_tb;
  localparam int NK = 52;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [63:0] plaintext = '0;
  logic [5:0]  key_addr;
  logic [15:0] key_data = '0;
  logic [63:0] ciphertext;
  logic        done;

  logic [15:0] kmem [0:NK-1];
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  cipher64_core u_dut (
    .clk(clk), .rst(rst), .start(start), .plaintext(plaintext),
    .key_addr(key_addr), .key_data(key_data), .ciphertext(ciphertext), .done(done)
  );

  always @(posedge clk) key_data <= (key_addr < 6'(NK)) ? kmem[key_addr] : 16'h0;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles, expected fewer than 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic int unsigned mm(input int unsigned a, input int unsigned b);
    longint unsigned av, bv, p;
    av = (a == 0) ? 64'd65536 : 64'(a);
    bv = (b == 0) ? 64'd65536 : 64'(b);
    p  = (av * bv) % 64'd65537;
    return (p == 64'd65536) ? 0 : int'(p);
  endfunction

  function automatic logic [63:0] model(input logic [63:0] pt);
    int unsigned a, b, c, d, u, v;
    a = pt[63:48]; b = pt[47:32]; c = pt[31:16]; d = pt[15:0];
    for (int r = 0; r < 8; r++) begin
      a = mm(a, kmem[r*6]);
      b = (b + kmem[r*6+1]) & 32'hFFFF;
      c = (c + kmem[r*6+2]) & 32'hFFFF;
      d = mm(d, kmem[r*6+3]);
      u = c;
      c = mm(c ^ a, kmem[r*6+4]);
      v = b;
      b = mm(((b ^ d) + c) & 32'hFFFF, kmem[r*6+5]);
      c = (c + b) & 32'hFFFF;
      a = a ^ b;
      d = d ^ c;
      b = b ^ u;
      c = c ^ v;
    end
    a = mm(a, kmem[48]);
    c = (c + kmem[49]) & 32'hFFFF;
    b = (b + kmem[50]) & 32'hFFFF;
    d = mm(d, kmem[51]);
    return {a[15:0], c[15:0], b[15:0], d[15:0]};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic fill_keys(input int mode);
    for (int i = 0; i < NK; i++) begin
      case (mode)
        0: kmem[i] = 16'h0000;
        1: kmem[i] = 16'hFFFF;
        2: kmem[i] = 16'(i + 1);
        default: kmem[i] = (($urandom % 8) == 0) ? 16'h0 : 16'($urandom);
      endcase
    end
  endtask

  task automatic run(input logic [63:0] pt, input bit inject);
    logic [63:0] exp, held;
    int cnt;
    bit addr_ok;
    exp = model(pt);
    addr_ok = 1'b1;
    @(negedge clk);
    start = 1'b1;
    plaintext = pt;
    @(negedge clk);
    start = 1'b0;
    cnt = 0;
    while (!done && cnt < 200) begin
      if (cnt <= 51 && key_addr != 6'(cnt)) addr_ok = 1'b0;
      if (inject && cnt == 10) begin
        start = 1'b1;
        plaintext = ~pt;
      end
      if (inject && cnt == 11) start = 1'b0;
      @(negedge clk);
      cnt++;
    end
    check(addr_ok, "R6 key address sequence", 64'(key_addr), 64'd51);
    check(cnt == 53, inject ? "R8 latency with start while busy" : "R7 done latency",
          64'(cnt), 64'd53);
    check(ciphertext == exp, inject ? "R8 result of first block" : "R1 R2 R3 R4 R5 ciphertext",
          ciphertext, exp);
    held = ciphertext;
    @(negedge clk);
    check(done == 1'b0, "R7 done is one cycle", 64'(done), 64'd0);
    @(negedge clk);
    @(negedge clk);
    check(ciphertext == held, "R9 ciphertext held", ciphertext, held);
  endtask

  initial begin
    fill_keys(0);
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R10 reset done", 64'(done), 64'd0);
    check(ciphertext == 64'h0, "R10 reset ciphertext", ciphertext, 64'h0);
    check(key_addr == 6'd0, "R10 reset key_addr", 64'(key_addr), 64'd0);
    @(negedge clk);
    rst = 1'b0;
    // R2 zero operands everywhere
    run(64'h0, 1'b0);
    run(64'h0001_0000_FFFF_0000, 1'b0);
    // R3 wrap on every addition
    fill_keys(1);
    run(64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
    run(64'h8000_0001_7FFF_0002, 1'b0);
    // R4 R6 distinct ordered keys
    fill_keys(2);
    run(64'h0123_4567_89AB_CDEF, 1'b0);
    // R1 R5 word placement under asymmetric input
    run(64'h0000_0000_0000_0001, 1'b0);
    run(64'h0001_0000_0000_0000, 1'b0);
    // R8 start while busy
    run(64'hDEAD_BEEF_0BAD_F00D, 1'b1);
    for (int n = 0; n < 40; n++) begin
      logic [63:0] p;
      fill_keys(3);
      p = {$urandom, $urandom};
      if ((n % 4) == 1) p[47:32] = 16'h0;
      if ((n % 4) == 2) p[63:48] = 16'h0;
      run(p, (n % 5) == 0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule